// File: doc/BRIEF.md
# Paged ROM Bank-Switching Memory Mapper

This block turns each access of an 8-bit CPU with a 16-bit address bus into a memory select and a physical address for one of three synchronous memories: cartridge ROM, battery-backed save RAM and an 8 KB system RAM. The lower 48 KB of the CPU space is split into three 16 KB windows. Each window takes its ROM page from its own page register. The third window can instead show one of two 16 KB save-RAM pages. The first 1 KB of the space is pinned to the start of ROM, so reset and interrupt vectors stay fixed whatever page register 0 holds.

The top 16 KB is system RAM, decoded on the low 13 address bits, so it appears twice. The paging registers sit on the last four byte addresses of that RAM region. A write there updates a register and also lands in RAM, so software can read back the last value it wrote. A mode input selects a boot-firmware variant. In that variant save RAM is never mapped, and an external cartridge-disable bit blanks every read below the RAM region to zero. A sticky flag reports that save RAM has been written since reset.

Top module: `mem_pager`

## Requirements
- R1: After reset, page registers 0, 1 and 2 hold 0, 1 and 2, the third window shows ROM and the save-RAM modified flag is 0.
- R2: CPU addresses 0x0000-0x03FF always read ROM page 0 at the same offset, whatever page register 0 holds.
- R3: A write to 0xFFFD, 0xFFFE or 0xFFFF loads page register 0, 1 or 2. Accesses from the next cycle on read ROM at page×16384 plus the low 14 address bits. Other writes leave the page registers unchanged.
- R4: The stored page number is the written byte modulo the ROM_PAGES parameter. With 16 pages, 0x13 gives page 3 and 0x25 gives page 5.
- R5: A write to 0xFFFC with bit 3 set maps save RAM into 0x8000-0xBFFF. Bit 2 chooses save-RAM page 0 when it is 0 and page 1 when it is 1. A write with bit 3 clear maps ROM page register 2 back into that window.
- R6: While save RAM is mapped, writes to 0x8000-0xBFFF store into the selected page and set the modified flag, which then stays set until reset. While ROM is mapped, such writes store nothing and leave the flag unchanged.
- R7: 0xC000-0xFFFF reads and writes system RAM at the low 13 address bits, so 0xE000-0xFFFF mirrors 0xC000-0xDFFF.
- R8: Writes to 0xFFFC-0xFFFF also store the byte into system RAM, where it can be read back.
- R9: In boot mode, save RAM is never mapped and never written, and the modified flag does not change. When cart_off is 1 in boot mode, every read below 0xC000 returns 0x00 and system RAM reads are unaffected.
- R10: Read data appears on cpu_rdata one clock after the address is presented, which matches the latency of the synchronous memories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| boot_mode | input | 1 | 1 selects the boot-firmware variant |
| cart_off | input | 1 | Cartridge-disable bit from the I/O control port (used in boot mode) |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | $clog2(ROM_PAGES)+14 | ROM physical address |
| rom_rdata | input | 8 | ROM read data, one cycle after rom_addr |
| sram_addr | output | 15 | Save-RAM address: page bit and 14 offset bits |
| sram_we | output | 1 | Save-RAM write enable |
| sram_wdata | output | 8 | Save-RAM write data |
| sram_rdata | input | 8 | Save-RAM read data, one cycle after sram_addr |
| wram_addr | output | 13 | System-RAM address |
| wram_we | output | 1 | System-RAM write enable |
| wram_wdata | output | 8 | System-RAM write data |
| wram_rdata | input | 8 | System-RAM read data, one cycle after wram_addr |
| sram_dirty | output | 1 | Sticky save-RAM modified flag |

## Verification
A single write to 0xFFFC-0xFFFF does two things in the same cycle: it updates a mapping register and it stores into system RAM. Both effects are judged on that one stimulus. The following accesses to the paged window must show the new mapping, and reads of the register address and of its mirror below 0xE000 must return the written byte. The bench also checks that a mapping change takes effect on the very next access. It does this by writing the save-RAM control byte and then reading the third window on the next cycle. Data written to each save-RAM page must come back only from that page. A write made while ROM is mapped must leave save RAM and the modified flag untouched.

// File: rtl/pager_pkg.sv
package pager_pkg;

    typedef enum logic [1:0] {
        SEL_ROM  = 2'd0,
        SEL_SRAM = 2'd1,
        SEL_WRAM = 2'd2,
        SEL_ZERO = 2'd3
    } mem_sel_e;

    localparam int WIN_BITS   = 14;   // 16 KB window offset
    localparam int FIXED_BITS = 10;   // 1 KB unpaged region
    localparam int WRAM_AW    = 13;   // 8 KB system RAM
    localparam int SRAM_AW    = WIN_BITS + 1;

endpackage

// File: rtl/pager_regs.sv
module pager_regs #(
    parameter int ROM_PAGES = 16,
    parameter int PW        = $clog2(ROM_PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [7:0]    reg_data,
    input  logic          sram_store,
    output logic [PW-1:0] page0,
    output logic [PW-1:0] page1,
    output logic [PW-1:0] page2,
    output logic          sram_on,
    output logic          sram_pg,
    output logic          sram_dirty
);

    typedef struct packed {
        logic [PW-1:0] pg0;
        logic [PW-1:0] pg1;
        logic [PW-1:0] pg2;
        logic          on;
        logic          pg;
        logic          dirty;
    } regs_t;

    function automatic logic [PW-1:0] fold(input logic [7:0] v);
        logic [8:0] m;
        m = {1'b0, v} % 9'(ROM_PAGES);
        return m[PW-1:0];
    endfunction

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_sel)
                2'd0: begin
                    r_d.on = reg_data[3];
                    r_d.pg = reg_data[2];
                end
                2'd1: r_d.pg0 = fold(reg_data);
                2'd2: r_d.pg1 = fold(reg_data);
                default: r_d.pg2 = fold(reg_data);
            endcase
        end
        if (sram_store) begin
            r_d.dirty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pg0   <= fold(8'd0);
            r_q.pg1   <= fold(8'd1);
            r_q.pg2   <= fold(8'd2);
            r_q.on    <= 1'b0;
            r_q.pg    <= 1'b0;
            r_q.dirty <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign page0      = r_q.pg0;
    assign page1      = r_q.pg1;
    assign page2      = r_q.pg2;
    assign sram_on    = r_q.on;
    assign sram_pg    = r_q.pg;
    assign sram_dirty = r_q.dirty;

    AST_DIRTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dirty |=> sram_dirty); // R6

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable({page0, page1, page2})); // R3

    AST_PAGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(page0) < ROM_PAGES) && (32'(page1) < ROM_PAGES) && (32'(page2) < ROM_PAGES)); // R4

endmodule

// File: rtl/pager_decode.sv
module pager_decode
    import pager_pkg::*;
#(
    parameter int PW     = 4,
    parameter int ROM_AW = PW + WIN_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_wr,
    input  logic               boot_mode,
    input  logic               cart_off,
    input  logic [PW-1:0]      page0,
    input  logic [PW-1:0]      page1,
    input  logic [PW-1:0]      page2,
    input  logic               sram_on,
    input  logic               sram_pg,
    output mem_sel_e           sel,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_we,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic               wram_we,
    output logic               reg_we
);

    logic [1:0]    slot;
    logic          fixed_area;
    logic [PW-1:0] pg;

    assign slot       = cpu_addr[15:14];
    assign fixed_area = (cpu_addr[15:FIXED_BITS] == '0);

    always_comb begin
        pg  = '0;
        sel = SEL_ROM;
        if (slot == 2'b11) begin
            sel = SEL_WRAM;
        end else if (boot_mode && cart_off) begin
            sel = SEL_ZERO;
        end else begin
            case (slot)
                2'b00: pg = fixed_area ? '0 : page0;
                2'b01: pg = page1;
                default: begin
                    pg = page2;
                    if (sram_on && !boot_mode) begin
                        sel = SEL_SRAM;
                    end
                end
            endcase
        end
    end

    assign rom_addr  = {pg, cpu_addr[WIN_BITS-1:0]};
    assign sram_addr = {sram_pg, cpu_addr[WIN_BITS-1:0]};
    assign wram_addr = cpu_addr[WRAM_AW-1:0];
    assign sram_we   = cpu_wr && (sel == SEL_SRAM);
    assign wram_we   = cpu_wr && (sel == SEL_WRAM);
    assign reg_we    = cpu_wr && (cpu_addr[15:2] == 14'h3FFF);

    AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_ROM) && (cpu_addr[15:FIXED_BITS] == '0))
            |-> (rom_addr[ROM_AW-1:WIN_BITS] == '0)); // R2

    AST_REG_WRAM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> wram_we); // R8

    AST_BOOT_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        boot_mode |-> (sel != SEL_SRAM) && !sram_we); // R9

    AST_SRAM_WE_SLOT2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (cpu_addr[15:14] == 2'b10) && sram_on); // R6

endmodule

// File: rtl/pager_rdmux.sv
module pager_rdmux
    import pager_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mem_sel_e   sel,
    input  logic [7:0] rom_rdata,
    input  logic [7:0] sram_rdata,
    input  logic [7:0] wram_rdata,
    output logic [7:0] cpu_rdata
);

    typedef struct packed {
        mem_sel_e sel;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.sel = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.sel <= SEL_ROM;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        case (rd_q.sel)
            SEL_ROM:  cpu_rdata = rom_rdata;
            SEL_SRAM: cpu_rdata = sram_rdata;
            SEL_WRAM: cpu_rdata = wram_rdata;
            default:  cpu_rdata = 8'h00;
        endcase
    end

    AST_SEL_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_WRAM) |=> (cpu_rdata == wram_rdata)); // R10

endmodule

// File: rtl/mem_pager.sv
module mem_pager
    import pager_pkg::*;
#(
    parameter int ROM_PAGES = 16,
    localparam int PW       = $clog2(ROM_PAGES),
    localparam int ROM_AW   = PW + WIN_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               cpu_wr,
    input  logic               boot_mode,
    input  logic               cart_off,
    output logic [7:0]         cpu_rdata,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [7:0]         rom_rdata,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_we,
    output logic [7:0]         sram_wdata,
    input  logic [7:0]         sram_rdata,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic               wram_we,
    output logic [7:0]         wram_wdata,
    input  logic [7:0]         wram_rdata,
    output logic               sram_dirty
);

    logic [PW-1:0] page0, page1, page2;
    logic          sram_on, sram_pg, reg_we;
    mem_sel_e      sel;

    pager_regs #(
        .ROM_PAGES (ROM_PAGES),
        .PW        (PW)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (cpu_addr[1:0]),
        .reg_data   (cpu_wdata),
        .sram_store (sram_we),
        .page0      (page0),
        .page1      (page1),
        .page2      (page2),
        .sram_on    (sram_on),
        .sram_pg    (sram_pg),
        .sram_dirty (sram_dirty)
    );

    pager_decode #(
        .PW     (PW),
        .ROM_AW (ROM_AW)
    ) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .boot_mode (boot_mode),
        .cart_off  (cart_off),
        .page0     (page0),
        .page1     (page1),
        .page2     (page2),
        .sram_on   (sram_on),
        .sram_pg   (sram_pg),
        .sel       (sel),
        .rom_addr  (rom_addr),
        .sram_addr (sram_addr),
        .sram_we   (sram_we),
        .wram_addr (wram_addr),
        .wram_we   (wram_we),
        .reg_we    (reg_we)
    );

    pager_rdmux i_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .rom_rdata  (rom_rdata),
        .sram_rdata (sram_rdata),
        .wram_rdata (wram_rdata),
        .cpu_rdata  (cpu_rdata)
    );

    assign sram_wdata = cpu_wdata;
    assign wram_wdata = cpu_wdata;

endmodule

// File: tb/test_mem_pager.sv
`timescale 1ns/1ps
module test_mem_pager;

    localparam int NPAGES = 16;
    localparam int RAW    = $clog2(NPAGES) + 14;
    localparam int NVEC   = 35;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    cpu_addr = 16'h0000;
    logic [7:0]     cpu_wdata = 8'h00;
    logic           cpu_wr = 1'b0;
    logic           boot_mode = 1'b0;
    logic           cart_off = 1'b0;
    logic [7:0]     cpu_rdata;
    logic [RAW-1:0] rom_addr;
    logic [7:0]     rom_rdata;
    logic [14:0]    sram_addr;
    logic           sram_we;
    logic [7:0]     sram_wdata;
    logic [7:0]     sram_rdata;
    logic [12:0]    wram_addr;
    logic           wram_we;
    logic [7:0]     wram_wdata;
    logic [7:0]     wram_rdata;
    logic           sram_dirty;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mem_pager #(.ROM_PAGES(NPAGES)) i_mem_pager (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .boot_mode(boot_mode), .cart_off(cart_off),
        .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .sram_addr(sram_addr), .sram_we(sram_we), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata), .wram_addr(wram_addr), .wram_we(wram_we),
        .wram_wdata(wram_wdata), .wram_rdata(wram_rdata), .sram_dirty(sram_dirty)
    );

    // Memory models: ROM byte = offset low byte XOR (page << 4)
    logic [7:0] sram_m [256] = '{default: 8'h00};
    logic [7:0] wram_m [256] = '{default: 8'h00};
    logic [7:0] s_idx, w_idx;
    assign s_idx = {sram_addr[14], sram_addr[6:0]};
    assign w_idx = {wram_addr[12], wram_addr[6:0]};

    always @(posedge clk) begin
        rom_rdata  <= rom_addr[7:0] ^ {rom_addr[17:14], 4'h0};
        sram_rdata <= sram_m[s_idx];
        wram_rdata <= wram_m[w_idx];
        if (sram_we) sram_m[s_idx] <= sram_wdata;
        if (wram_we) wram_m[w_idx] <= wram_wdata;
    end

    // {read, req, addr, wdata, expected}
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b1, 4'd1, 16'h0005, 8'h00, 8'h05},  // R1 fixed area
        {1'b1, 4'd1, 16'h0405, 8'h00, 8'h05},  // R1 page0 = 0
        {1'b1, 4'd1, 16'h4005, 8'h00, 8'h15},  // R1 page1 = 1
        {1'b1, 4'd1, 16'h8005, 8'h00, 8'h25},  // R1 page2 = 2
        {1'b0, 4'd3, 16'hFFFD, 8'h03, 8'h00},  // R3 page0 <- 3
        {1'b1, 4'd3, 16'h0405, 8'h00, 8'h35},  // R3
        {1'b1, 4'd2, 16'h0010, 8'h00, 8'h10},  // R2 still page 0
        {1'b1, 4'd2, 16'h03FF, 8'h00, 8'hFF},  // R2 top of fixed area
        {1'b0, 4'd4, 16'hFFFE, 8'h13, 8'h00},  // R4 0x13 % 16 = 3
        {1'b1, 4'd4, 16'h4001, 8'h00, 8'h31},  // R4
        {1'b0, 4'd3, 16'hFFFF, 8'h07, 8'h00},  // R3 page2 <- 7
        {1'b1, 4'd3, 16'hBF02, 8'h00, 8'h72},  // R3
        {1'b0, 4'd4, 16'hFFFF, 8'h25, 8'h00},  // R4 0x25 % 16 = 5
        {1'b1, 4'd4, 16'h8000, 8'h00, 8'h50},  // R4
        {1'b0, 4'd6, 16'h8002, 8'hAA, 8'h00},  // R6 ROM mapped: ignored
        {1'b1, 4'd6, 16'h8002, 8'h00, 8'h52},  // R6
        {1'b0, 4'd5, 16'hFFFC, 8'h08, 8'h00},  // R5 save RAM page 0
        {1'b1, 4'd6, 16'h8002, 8'h00, 8'h00},  // R6 earlier write not stored
        {1'b0, 4'd6, 16'h8002, 8'h5A, 8'h00},  // R6
        {1'b1, 4'd6, 16'h8002, 8'h00, 8'h5A},  // R6
        {1'b0, 4'd5, 16'hFFFC, 8'h0C, 8'h00},  // R5 save RAM page 1
        {1'b1, 4'd5, 16'h8002, 8'h00, 8'h00},  // R5
        {1'b0, 4'd5, 16'h8002, 8'hC3, 8'h00},  // R5
        {1'b1, 4'd5, 16'h8002, 8'h00, 8'hC3},  // R5
        {1'b0, 4'd5, 16'hFFFC, 8'h08, 8'h00},  // R5 back to page 0
        {1'b1, 4'd5, 16'h8002, 8'h00, 8'h5A},  // R5
        {1'b0, 4'd5, 16'hFFFC, 8'h00, 8'h00},  // R5 ROM again
        {1'b1, 4'd5, 16'h8002, 8'h00, 8'h52},  // R5
        {1'b0, 4'd7, 16'hC123, 8'h77, 8'h00},  // R7
        {1'b1, 4'd7, 16'hE123, 8'h00, 8'h77},  // R7 mirror
        {1'b0, 4'd7, 16'hFFF0, 8'h99, 8'h00},  // R7
        {1'b1, 4'd7, 16'hDFF0, 8'h00, 8'h99},  // R7 mirror
        {1'b1, 4'd8, 16'hFFFC, 8'h00, 8'h00},  // R8 last control byte
        {1'b1, 4'd8, 16'hDFFF, 8'h00, 8'h25},  // R8 last page2 byte
        {1'b1, 4'd8, 16'hDFFD, 8'h00, 8'h03}   // R8 last page0 byte
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    // data returns one clock after the address (R10)
    task automatic do_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_wr   = 1'b0;
        @(negedge clk);
        d = cpu_rdata;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        reset_dut();
        // R1 flag clear after reset
        check("R1", {7'd0, sram_dirty}, 8'h00);
        // R6 write with ROM mapped leaves flag clear
        do_write(16'h8002, 8'hAA);
        @(negedge clk);
        check("R6", {7'd0, sram_dirty}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][36]) begin
                do_read(VEC[i][31:16], rd);
                check($sformatf("R%0d vec %0d", VEC[i][35:32], i), rd, VEC[i][7:0]);
            end else begin
                do_write(VEC[i][31:16], VEC[i][15:8]);
            end
        end
        // R6 flag set by save RAM writes and sticky after unmapping
        check("R6", {7'd0, sram_dirty}, 8'h01);

        // R10 mapping change seen on the very next access
        do_write(16'hFFFC, 8'h08);
        do_read(16'h8002, rd);
        check("R10", rd, 8'h5A);

        // R9 boot mode
        reset_dut();
        check("R1", {7'd0, sram_dirty}, 8'h00);
        boot_mode = 1'b1;
        do_write(16'hFFFC, 8'h08);
        do_read(16'h8005, rd);
        check("R9", rd, 8'h25);
        do_write(16'h8003, 8'h11);
        @(negedge clk);
        check("R9", {7'd0, sram_dirty}, 8'h00);
        cart_off = 1'b1;
        do_read(16'h0005, rd);
        check("R9", rd, 8'h00);
        do_read(16'h4005, rd);
        check("R9", rd, 8'h00);
        do_read(16'hBFFF, rd);
        check("R9", rd, 8'h00);
        do_read(16'hC123, rd);
        check("R9", rd, 8'h77);
        cart_off = 1'b0;
        do_read(16'h4005, rd);
        check("R9", rd, 8'h15);
        boot_mode = 1'b0;
        // R9 save RAM page 0 untouched by the boot-mode write
        do_write(16'hFFFC, 8'h08);
        do_read(16'h8003, rd);
        check("R9", rd, 8'h00);

        finish_run();
    end

endmodule